// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control address that selects the next microinstruction in a microprogrammed control unit with a 128-word control store. In each cycle it looks at the sequencing part of the microinstruction currently being executed. That part has a two-bit condition selector, a two-bit branch kind and a 7-bit target field. The block also takes three status flags from the datapath and the four opcode bits of the instruction held in the data register. From these it picks where the control address register goes next.

There are four possible sources. The first is the current address plus one. The second is a single-entry return register used for one level of microsubroutine. The third is the target field of the microinstruction. The fourth is an address formed from the opcode, so that each machine instruction gets its own four-word routine slot in the lower half of the store. The address source code and the return-register load strobe are driven out as ports, so the datapath side and a testbench can see them. Reset points the sequencer at the first word of the fetch routine.

Top module: `usq_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the control address to 64 and clears the return register to 0, so a return issued right after reset goes to address 0.
- R2: The test bit is selected by cond_sel: 00 gives a constant 1, 01 gives dr_ind, 10 gives ac_sign, and 11 gives ac_zero.
- R3: Branch kind 00 (jump) loads the control address from addr_field when the test bit is 1, and loads the control address plus one when it is 0.
- R4: Branch kind 01 (call) with the test bit at 1 loads the control address from addr_field and loads the return register with the old control address plus one.
- R5: Branch kind 01 with the test bit at 0 loads the control address plus one and leaves the return register unchanged.
- R6: Branch kind 10 (return) loads the control address from the return register, whatever the test bit is.
- R7: Branch kind 11 (map) loads the control address with a 0 in bit 6, op_bits in bits 5..2 and zeros in bits 1..0, whatever the test bit is.
- R8: src_sel shows the source chosen for the next address in the same cycle: 00 for plus one, 01 for the return register, 10 for addr_field, and 11 for the mapped opcode.
- R9: sbr_load is 1 only when the branch kind is 01 and the test bit is 1. Otherwise it is 0.
- R10: Incrementing from address 127 gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition selector of the current microinstruction |
| br_type | input | 2 | Branch kind of the current microinstruction |
| addr_field | input | 7 | Target address field of the current microinstruction |
| op_bits | input | 4 | Opcode bits of the instruction in the data register |
| dr_ind | input | 1 | Indirect-address flag from the data register |
| ac_sign | input | 1 | Accumulator sign flag |
| ac_zero | input | 1 | Accumulator-equals-zero flag |
| car | output | 7 | Control address register, addresses the control store |
| src_sel | output | 2 | Source code of the next address (combinational) |
| sbr_load | output | 1 | Return-register load strobe (combinational) |

## Verification
The bench uses the default parameters: a 7-bit address, a 4-bit opcode, two slot bits and a reset address of 64. These values keep the whole address space small. Walking the control address up to 127 and across the wrap takes only a few cycles, and all sixteen opcode slots can be mapped one after another. They also let the random stimulus reach every pairing of condition selector, flag value and branch kind many times. Calls that are not taken followed by returns then show that the saved return address was left as it was.

// File: rtl/usq_pkg.sv
package usq_pkg;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    SRC_INC   = 2'b00,
    SRC_SBR   = 2'b01,
    SRC_FIELD = 2'b10,
    SRC_MAP   = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    CND_ONE  = 2'b00,
    CND_IND  = 2'b01,
    CND_SIGN = 2'b10,
    CND_ZERO = 2'b11
  } cnd_e;

endpackage

// File: rtl/usq_test_mux.sv
module usq_test_mux
  import usq_pkg::*;
(
  input  cnd_e cond_sel,
  input  logic dr_ind,
  input  logic ac_sign,
  input  logic ac_zero,
  output logic test_bit
);

  always_comb begin
    unique case (cond_sel)
      CND_ONE:  test_bit = 1'b1;
      CND_IND:  test_bit = dr_ind;
      CND_SIGN: test_bit = ac_sign;
      CND_ZERO: test_bit = ac_zero;
      default:  test_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/usq_branch_ctl.sv
module usq_branch_ctl
  import usq_pkg::*;
(
  input  br_kind_e br_type,
  input  logic     test_bit,
  output src_e     src_sel,
  output logic     sbr_load
);

  always_comb begin
    src_sel  = SRC_INC;
    sbr_load = 1'b0;
    unique case (br_type)
      BR_JMP:  src_sel = test_bit ? SRC_FIELD : SRC_INC;
      BR_CALL: begin
        src_sel  = test_bit ? SRC_FIELD : SRC_INC;
        sbr_load = test_bit;
      end
      BR_RET:  src_sel = SRC_SBR;
      BR_MAP:  src_sel = SRC_MAP;
      default: src_sel = SRC_INC;
    endcase
  end

endmodule

// File: rtl/usq_addr_path.sv
module usq_addr_path
  import usq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int SLOT_BITS  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  src_e              src_sel,
  input  logic              sbr_load,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [OP_W-1:0]   op_bits,
  output logic [ADDR_W-1:0] car_q,
  output logic [ADDR_W-1:0] car_inc,
  output logic [ADDR_W-1:0] map_addr,
  output logic [ADDR_W-1:0] next_addr
);

  localparam int PAD_W = ADDR_W - OP_W - SLOT_BITS;
  localparam logic [ADDR_W-1:0] RST_CAR = RESET_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ONE     = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] sbr_q;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + ONE;
  endfunction

  assign car_inc = bump(car_q);

  generate
    if (PAD_W > 0) begin : g_map_pad
      assign map_addr = {{PAD_W{1'b0}}, op_bits, {SLOT_BITS{1'b0}}};
    end else begin : g_map_full
      assign map_addr = {op_bits, {SLOT_BITS{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (src_sel)
      SRC_INC:   next_addr = car_inc;
      SRC_SBR:   next_addr = sbr_q;
      SRC_FIELD: next_addr = addr_field;
      SRC_MAP:   next_addr = map_addr;
      default:   next_addr = car_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= RST_CAR;
      sbr_q <= '0;
    end else begin
      car_q <= next_addr;
      if (sbr_load) sbr_q <= car_inc;
    end
  end

endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int SLOT_BITS  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        br_type,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [OP_W-1:0]   op_bits,
  input  logic              dr_ind,
  input  logic              ac_sign,
  input  logic              ac_zero,
  output logic [ADDR_W-1:0] car,
  output logic [1:0]        src_sel,
  output logic              sbr_load
);

  logic              test_bit;
  src_e              src_w;
  logic [ADDR_W-1:0] car_inc;
  logic [ADDR_W-1:0] map_addr;
  logic [ADDR_W-1:0] next_addr;

  usq_test_mux u_test (
    .cond_sel (cnd_e'(cond_sel)),
    .dr_ind   (dr_ind),
    .ac_sign  (ac_sign),
    .ac_zero  (ac_zero),
    .test_bit (test_bit)
  );

  usq_branch_ctl u_ctl (
    .br_type  (br_kind_e'(br_type)),
    .test_bit (test_bit),
    .src_sel  (src_w),
    .sbr_load (sbr_load)
  );

  usq_addr_path #(
    .ADDR_W     (ADDR_W),
    .OP_W       (OP_W),
    .SLOT_BITS  (SLOT_BITS),
    .RESET_ADDR (RESET_ADDR)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .src_sel    (src_w),
    .sbr_load   (sbr_load),
    .addr_field (addr_field),
    .op_bits    (op_bits),
    .car_q      (car),
    .car_inc    (car_inc),
    .map_addr   (map_addr),
    .next_addr  (next_addr)
  );

  assign src_sel = src_w;

endmodule

// File: rtl/usq_sequencer_chk.sv
module usq_sequencer_chk #(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int SLOT_BITS  = 2,
  parameter int RESET_ADDR = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cond_sel,
  input logic [1:0]        br_type,
  input logic [ADDR_W-1:0] addr_field,
  input logic [OP_W-1:0]   op_bits,
  input logic              dr_ind,
  input logic              ac_sign,
  input logic              ac_zero,
  input logic [ADDR_W-1:0] car,
  input logic [1:0]        src_sel,
  input logic              sbr_load,
  input logic              test_bit
);

  localparam logic [ADDR_W-1:0] RST_CAR = RESET_ADDR[ADDR_W-1:0];

  // R1
  reset_addr_chk: assert property (@(posedge clk) rst |=> car == RST_CAR);

  // R2
  cond_ind_chk: assert property (@(posedge clk) disable iff (rst)
    cond_sel == 2'b01 |-> test_bit == dr_ind);

  // R3
  jump_always_chk: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b00 && cond_sel == 2'b00) |=> car == $past(addr_field));

  // R3
  jump_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (br_type == 2'b00 && cond_sel == 2'b11 && !ac_zero) |=> car == ADDR_W'($past(car) + 1));

  // R6
  ret_src_chk: assert property (@(posedge clk) disable iff (rst)
    br_type == 2'b10 |-> src_sel == 2'b01);

  // R7
  map_addr_chk: assert property (@(posedge clk) disable iff (rst)
    br_type == 2'b11 |=> car == (ADDR_W'($past(op_bits)) << SLOT_BITS));

  // R9
  load_kind_chk: assert property (@(posedge clk) disable iff (rst)
    sbr_load |-> (br_type == 2'b01 && src_sel == 2'b10));

  // R8
  sign_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 2'b10 && br_type[1] == 1'b0) |-> src_sel == (ac_sign ? 2'b10 : 2'b00));

endmodule

bind usq_sequencer usq_sequencer_chk #(
  .ADDR_W     (ADDR_W),
  .OP_W       (OP_W),
  .SLOT_BITS  (SLOT_BITS),
  .RESET_ADDR (RESET_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cond_sel   (cond_sel),
  .br_type    (br_type),
  .addr_field (addr_field),
  .op_bits    (op_bits),
  .dr_ind     (dr_ind),
  .ac_sign    (ac_sign),
  .ac_zero    (ac_zero),
  .car        (car),
  .src_sel    (src_sel),
  .sbr_load   (sbr_load),
  .test_bit   (test_bit)
);

// File: tb/usq_sequencer_test.sv
`timescale 1ns/1ps
module usq_sequencer_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cond_sel;
  logic [1:0] br_type;
  logic [6:0] addr_field;
  logic [3:0] op_bits;
  logic       dr_ind, ac_sign, ac_zero;
  logic [6:0] car;
  logic [1:0] src_sel;
  logic       sbr_load;

  int tests = 0;
  int fails = 0;
  int ref_car;
  int ref_sbr;
  bit done = 0;

  always #2.5 clk = ~clk;

  usq_sequencer uut (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_type(br_type),
    .addr_field(addr_field), .op_bits(op_bits), .dr_ind(dr_ind),
    .ac_sign(ac_sign), .ac_zero(ac_zero), .car(car),
    .src_sel(src_sel), .sbr_load(sbr_load)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string kind_tag(input int br, input bit t);
    case (br)
      0: return "R3";
      1: return t ? "R4" : "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cyc(input int cs, input int br, input int ad, input int op,
                     input bit di, input bit sg, input bit zr);
    bit t;
    int exp_sel;
    bit exp_ld;
    int old;
    cond_sel = cs[1:0]; br_type = br[1:0]; addr_field = ad[6:0];
    op_bits = op[3:0]; dr_ind = di; ac_sign = sg; ac_zero = zr;
    #1;
    if (cs == 0) t = 1; else if (cs == 1) t = di; else if (cs == 2) t = sg; else t = zr;
    old = ref_car;
    exp_ld = 0;
    if (br == 0) begin
      exp_sel = t ? 2 : 0;
      ref_car = t ? ad : (old + 1) % 128;
    end else if (br == 1) begin
      exp_sel = t ? 2 : 0;
      exp_ld = t;
      if (t) ref_sbr = (old + 1) % 128;
      ref_car = t ? ad : (old + 1) % 128;
    end else if (br == 2) begin
      exp_sel = 1;
      ref_car = ref_sbr;
    end else begin
      exp_sel = 3;
      ref_car = op * 4;
    end
    check(int'(src_sel) == exp_sel, "R8/R2", int'(src_sel), exp_sel);
    check(sbr_load == exp_ld, "R9", int'(sbr_load), int'(exp_ld));
    @(posedge clk);
    @(negedge clk);
    check(int'(car) == ref_car, kind_tag(br, t), int'(car), ref_car);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; cond_sel = 0; br_type = 0; addr_field = 0; op_bits = 0;
    dr_ind = 0; ac_sign = 0; ac_zero = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    ref_car = 64; ref_sbr = 0;
    // R1: reset address and cleared return register
    check(int'(car) == 64, "R1", int'(car), 64);
    cyc(0, 2, 0, 0, 0, 0, 0);
    check(int'(car) == 0, "R1", int'(car), 0);

    // R10: wrap from 127
    cyc(0, 0, 127, 0, 0, 0, 0);
    cyc(1, 0, 5, 0, 0, 0, 0);
    check(int'(car) == 0, "R10", int'(car), 0);

    // R2/R3: every selector, both flag values
    cyc(1, 0, 20, 0, 1, 0, 0);
    cyc(2, 0, 30, 0, 0, 1, 0);
    cyc(2, 0, 40, 0, 0, 0, 1);
    cyc(3, 0, 50, 0, 0, 0, 1);
    cyc(3, 0, 60, 0, 1, 1, 0);

    // R4/R5/R6: call taken, call missed keeps return, return
    cyc(0, 0, 10, 0, 0, 0, 0);
    cyc(0, 1, 90, 0, 0, 0, 0);
    cyc(1, 1, 33, 0, 0, 1, 1);
    cyc(3, 2, 0, 0, 1, 1, 0);
    check(int'(car) == 11, "R5", int'(car), 11);

    // R7: all opcodes, test bit irrelevant
    for (int k = 0; k < 16; k++) cyc(k % 4, 3, 127, k, k[0], k[1], k[2]);

    // mixed stimulus against the reference model
    for (int n = 0; n < 2000; n++)
      cyc($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 127),
          $urandom_range(0, 15), 1'($urandom), 1'($urandom), 1'($urandom));

    // R1: reset in mid-run
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    ref_car = 64; ref_sbr = 0;
    check(int'(car) == 64, "R1", int'(car), 64);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule